// File: doc/BRIEF.md
# Optical Port Line Conditioner

This block sits between a dedicated UART and the pins of an infrared or optical link. On the transmit side it can gate the UART's serial output with a carrier of about 38 kHz. The carrier is derived from the system clock, and its duty cycle can be selected among four values. The transmit output polarity can be inverted. On the receive side the incoming pin level can be inverted before it reaches the UART.

Modulation is active only when it is enabled and system power is good. During brownout, or when modulation is off, the transmit pin simply follows the UART line, subject to its invert bit.

While modulating, a 0 data bit becomes a burst of carrier pulses. A 1 data bit leaves the line at its inactive (high) level. Each burst starts a fresh carrier period, so its first pulse is never truncated. The transmit pin is registered, so it lags the UART line by one clock. The receive path is purely combinational.

Top module: `optp_cond`

## Requirements
- R1: While rst_ni is low, pin_tx_o is 1.
- R2: When mod_en_i is 0, pin_tx_o one cycle after an edge equals uart_tx_i XOR tx_inv_i sampled at that edge.
- R3: When pwr_ok_i is 0 (brownout), pin_tx_o behaves as in R2 even if mod_en_i is 1, so no carrier appears.
- R4: While modulating (mod_en_i=1, pwr_ok_i=1), a uart_tx_i of 1 gives pin_tx_o = 1 XOR tx_inv_i on the next cycle.
- R5: While modulating with uart_tx_i held at 0, the output (before inversion) is low for the first L cycles of each carrier period of P cycles and high for the remaining P-L cycles, repeating with period P.
- R6: duty_sel_i selects L: code 0 gives P>>1 (50%), code 1 gives P>>2 (25%), code 2 gives P>>3 (12.5%), code 3 gives P>>4 (6.25%).
- R7: Every burst (uart_tx_i falling to 0 while modulating, or modulation becoming active while uart_tx_i is 0) restarts the carrier at the beginning of a period, so its first low pulse lasts a full L cycles.
- R8: tx_inv_i is applied after modulation: when it is 1, pin_tx_o is the exact complement of the non-inverted result.
- R9: uart_rx_o equals pin_rx_i XOR rx_inv_i combinationally.
- R10: P equals CLK_HZ/CARRIER_HZ rounded to the nearest integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uart_tx_i | input | 1 | Serial data from the UART transmitter |
| pwr_ok_i | input | 1 | 1 when main power is present, 0 in brownout |
| mod_en_i | input | 1 | Carrier modulation enable |
| duty_sel_i | input | 2 | Carrier low-time select (0:50%, 1:25%, 2:12.5%, 3:6.25%) |
| tx_inv_i | input | 1 | Invert transmit pin |
| rx_inv_i | input | 1 | Invert receive path |
| pin_rx_i | input | 1 | Receive pin level |
| pin_tx_o | output | 1 | Transmit pin level |
| uart_rx_o | output | 1 | Conditioned receive data to the UART |

## Verification
On every cycle, the assertions check four things:
- the pass-through relation when modulation is off or power is bad;
- the idle level during 1 bits while modulating;
- the receive inversion;
- the carrier counter staying in range, and restarting at zero at the start of each burst.

The pulse widths for each duty code, the period length and the full-width first pulse after a short interrupted burst can only be shown by the bench's cycle-by-cycle scenarios, which compare the pin against a phase model.

// File: rtl/optp_pkg.sv
package optp_pkg;

  typedef enum logic [1:0] {
    DUTY_HALF    = 2'd0,
    DUTY_QUARTER = 2'd1,
    DUTY_EIGHTH  = 2'd2,
    DUTY_SIXTEEN = 2'd3
  } duty_e;

  function automatic int unsigned carrier_period(int unsigned clk_hz, int unsigned car_hz);
    return (clk_hz + car_hz / 2) / car_hz;
  endfunction

endpackage

// File: rtl/optp_carrier.sv
module optp_carrier
  import optp_pkg::*;
#(
  parameter int unsigned PERIOD = 129,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] duty_i,
  output logic       low_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_len;
  logic [CW-1:0] len_tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_tbl[g] = CW'(PERIOD >> (g + 1));
  end

  assign low_len = len_tbl[duty_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign low_o = run_i && (cnt_q < low_len);

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_burst_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/optp_tx_path.sv
module optp_tx_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic mod_act_i,
  input  logic car_low_i,
  input  logic inv_i,
  output logic pin_o
);

  logic raw;
  logic pin_q;
  logic past_ok_q;

  // data 1 keeps line high; data 0 takes carrier shape
  assign raw = mod_act_i ? (data_i | ~car_low_i) : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q     <= 1'b1;
      past_ok_q <= 1'b0;
    end else begin
      pin_q     <= raw ^ inv_i;
      past_ok_q <= 1'b1;
    end
  end

  assign pin_o = pin_q;

  p_passthru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(mod_act_i) |-> pin_q == $past(data_i ^ inv_i));

  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(mod_act_i && data_i) |-> pin_q == !$past(inv_i));

endmodule

// File: rtl/optp_rx_path.sv
module optp_rx_path (
  input  logic pin_i,
  input  logic inv_i,
  output logic data_o
);

  assign data_o = pin_i ^ inv_i;

endmodule

// File: rtl/optp_cond.sv
module optp_cond
  import optp_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 4_915_200,
  parameter int unsigned CARRIER_HZ = 38_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uart_tx_i,
  input  logic       pwr_ok_i,
  input  logic       mod_en_i,
  input  logic [1:0] duty_sel_i,
  input  logic       tx_inv_i,
  input  logic       rx_inv_i,
  input  logic       pin_rx_i,
  output logic       pin_tx_o,
  output logic       uart_rx_o
);

  localparam int unsigned PERIOD = carrier_period(CLK_HZ, CARRIER_HZ);
  localparam int unsigned CW     = $clog2(PERIOD);

  logic mod_act;
  logic car_run;
  logic car_low;

  assign mod_act = mod_en_i & pwr_ok_i;
  assign car_run = mod_act & ~uart_tx_i;

  optp_carrier #(.PERIOD(PERIOD), .CW(CW)) u_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (car_run),
    .duty_i (duty_sel_i),
    .low_o  (car_low)
  );

  optp_tx_path u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (uart_tx_i),
    .mod_act_i (mod_act),
    .car_low_i (car_low),
    .inv_i     (tx_inv_i),
    .pin_o     (pin_tx_o)
  );

  optp_rx_path u_rx (
    .pin_i  (pin_rx_i),
    .inv_i  (rx_inv_i),
    .data_o (uart_rx_o)
  );

  p_brownout_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> !car_low);

  always_comb begin
    p_rx_inv_r9: assert (uart_rx_o == (pin_rx_i ^ rx_inv_i));
  end

endmodule

// File: tb/tb_optp_cond.sv
module tb_optp_cond;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 608_000;
  localparam int CAR_HZ = 38_000;
  localparam int P = 16;  // R10: round(608000/38000)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b1, pwr = 1'b1, men = 1'b0, tinv = 1'b0, rinv = 1'b0, prx = 1'b0;
  logic [1:0] duty = 2'd0;
  logic pin_tx, urx;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit done = 0;

  bit    q_exp[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  optp_cond #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_n), .uart_tx_i(tx), .pwr_ok_i(pwr),
    .mod_en_i(men), .duty_sel_i(duty), .tx_inv_i(tinv), .rx_inv_i(rinv),
    .pin_rx_i(prx), .pin_tx_o(pin_tx), .uart_rx_o(urx)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: inputs are already set; predict pin after the next edge
  task automatic step(input string tag);
    bit run;
    bit e;
    run = men && pwr && !tx;
    if (run) e = ((ph % P) < (P >> (duty + 1))) ? 1'b0 : 1'b1;
    else     e = tx;
    e ^= tinv;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(posedge clk);
    ph = run ? ph + 1 : 0;
    @(negedge clk);
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) check(pin_tx, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pin_tx, 1'b1, "R1 reset level");
    tinv = 1'b1;
    #1 check(pin_tx, 1'b1, "R1 reset level with invert");
    tinv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 pass-through
    begin
      bit pat [8] = '{0, 1, 1, 0, 1, 0, 0, 1};
      foreach (pat[i]) begin tx = pat[i]; step("R2 passthru"); end
      tinv = 1'b1;
      foreach (pat[i]) begin tx = pat[i]; step("R2 passthru inverted"); end
      tinv = 1'b0;
    end

    // R3 brownout suppresses carrier
    men = 1'b1; pwr = 1'b0; tx = 1'b0;
    run_n(2 * P, "R3 brownout low");
    tx = 1'b1;
    run_n(3, "R3 brownout high");
    pwr = 1'b1;

    // R4 idle while modulating
    run_n(5, "R4 idle high");

    // R5/R6 each duty code over two periods
    for (int d = 0; d < 4; d++) begin
      duty = d[1:0];
      tx = 1'b0;
      run_n(2 * P, $sformatf("R5 R6 duty code %0d", d));
      tx = 1'b1;
      run_n(3, "R4 idle between bursts");
    end

    // R7 restart after short burst
    duty = 2'd0;
    tx = 1'b0; run_n(5, "R7 short burst");
    tx = 1'b1; run_n(2, "R7 gap");
    tx = 1'b0; run_n(P + 4, "R7 full first pulse");
    // R7 modulation enabled mid-low data
    men = 1'b0; run_n(3, "R2 mod off");
    men = 1'b1; run_n(P, "R7 enable restart");
    tx = 1'b1; run_n(2, "R4 idle");

    // R8 invert applied after modulation
    tinv = 1'b1; duty = 2'd1;
    tx = 1'b0; run_n(2 * P, "R8 inverted carrier");
    tx = 1'b1; run_n(3, "R8 inverted idle");
    tinv = 1'b0;

    // R9 rx path
    for (int k = 0; k < 4; k++) begin
      prx = k[0]; rinv = k[1];
      #1 check(urx, k[0] ^ k[1], "R9 rx invert");
    end

    run_n(2, "R2 drain");
    @(negedge clk);
    finish_run();
  end

endmodule